// File: doc/BRIEF.md
# PLL Lock Detector

This block decides whether a phase-locked loop is in lock. It watches the UP and DOWN pulses of a phase-frequency detector (PFD) and counts, in ticks of a fast sample clock, how far apart the two rising edges are in each comparison cycle. A cycle is good when that gap is shorter than a threshold picked by a 3-bit code. Lock is declared once enough good cycles have come in a row, and that run length is picked by a second 3-bit code. Lock is dropped at once on the first bad cycle. A cycle is also bad when the second edge never arrives, or when the first pulse repeats before the second edge comes.

The lock output can be driven active-high or active-low. When automatic recalibration is enabled, a drop from locked to unlocked also produces a one-clock restart strobe. A VCO calibration controller uses this strobe to start a new band search. The strobe is held back while that controller reports that a calibration is already running.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset the internal lock state is clear, so lock_o equals lock_act_low_i, and cal_restart_o is 0.
- R2: The gap is the number of sample-clock edges between the rising edge of UP and the rising edge of DOWN, in either order. When both rise on the same edge the gap is 0. A cycle is good when gap < threshold ticks.
- R3: The threshold in ticks is 2000 ps × (thr_code_i + 1) / TICK_PS. With the default TICK_PS = 500 this is 4 × (code + 1), which spans 4 to 32 ticks (2 ns to 16 ns).
- R4: Lock is declared on the good cycle that completes the required run of consecutive good cycles. cnt_code_i values 0 through 7 select runs of 4, 8, 16, 32, 64, 256, 1024 and 4096 cycles. One cycle fewer leaves the block unlocked.
- R5: A single bad cycle drops lock at once and clears the run. After that, a full new run is needed to lock again.
- R6: A cycle is bad when the second edge has not arrived within TIMEOUT_TICKS edges of the first. It is also bad when the first signal rises again before the other one has risen.
- R7: lock_o is the internal lock state, inverted when lock_act_low_i is 1.
- R8: When autocal_en_i is 1 and cal_busy_i is 0, every fall of the internal lock state raises cal_restart_o for exactly one clock. Gaining lock raises no strobe.
- R9: No strobe is produced when autocal_en_i is 0 or when cal_busy_i is 1 as the lock state falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfd_up_i | input | 1 | UP pulse from the phase-frequency detector |
| pfd_dn_i | input | 1 | DOWN pulse from the phase-frequency detector |
| thr_code_i | input | 3 | Edge-gap threshold code |
| cnt_code_i | input | 3 | Required run-length code |
| lock_act_low_i | input | 1 | 1 selects an active-low lock output |
| autocal_en_i | input | 1 | Enables the recalibration strobe on loss of lock |
| cal_busy_i | input | 1 | A VCO calibration is in progress |
| lock_o | output | 1 | Lock indication with the selected polarity |
| cal_restart_o | output | 1 | One-clock strobe requesting VCO recalibration |

## Verification
Every threshold code is tried with one pair of cycles: one whose gap is a single tick under the threshold and one whose gap equals it. This pair tells a strict comparison apart from an inclusive one and shows that the code maps to the right tick count. Every run-length code is tried with one cycle fewer than required and then with exactly the required count, which pins down the lookup table.

Other patterns cover the failure cases:
- A missing DOWN edge, a repeated UP edge and a bad cycle in the middle of a run each tell the timeout, the repeat rule and the clearing of the run apart from one another.
- Strobe windows with the feature enabled, with it disabled and with a calibration already running separate the gating conditions.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

   localparam int unsigned RUN_W = 13;

   typedef enum logic [1:0] {
      GM_IDLE    = 2'd0,
      GM_WAIT_DN = 2'd1,
      GM_WAIT_UP = 2'd2
   } gm_state_e;

   // run-length code: 4,8,16,32,64 then 256,1024,4096
   function automatic logic [RUN_W-1:0] need_cycles(input logic [2:0] code);
      if (code < 3'd5)
         return RUN_W'(4) << code;
      else
         return RUN_W'(64) << (2 * (int'(code) - 4));
   endfunction

endpackage

// File: rtl/lockdet_gap_meter.sv
module lockdet_gap_meter
   import lockdet_pkg::*;
#(
   parameter int unsigned TICK_PS       = 500,
   parameter int unsigned TIMEOUT_TICKS = 48,
   parameter int unsigned IN_SYNC       = 1,
   localparam int unsigned GAP_W        = $clog2(TIMEOUT_TICKS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       up_i,
   input  logic       dn_i,
   input  logic [2:0] thr_code_i,
   output logic       done_o,
   output logic       good_o
);

   localparam int unsigned THR_UNIT = 2000 / TICK_PS;

   if (TICK_PS == 0 || (2000 % TICK_PS) != 0) begin : g_bad_tick
      $error("TICK_PS must divide 2000 ps");
   end
   if (8 * THR_UNIT >= TIMEOUT_TICKS) begin : g_bad_timeout
      $error("TIMEOUT_TICKS must exceed the largest threshold");
   end

   logic up_v, dn_v;

   if (IN_SYNC != 0) begin : g_sync
      logic [1:0] up_s, dn_s;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            up_s <= '0;
            dn_s <= '0;
         end else begin
            up_s <= {up_s[0], up_i};
            dn_s <= {dn_s[0], dn_i};
         end
      end
      assign up_v = up_s[1];
      assign dn_v = dn_s[1];
   end else begin : g_direct
      assign up_v = up_i;
      assign dn_v = dn_i;
   end

   logic            up_q, dn_q;
   logic            rise_up, rise_dn;
   gm_state_e       state;
   logic [GAP_W-1:0] cnt;
   logic [GAP_W-1:0] gap_next;
   logic [GAP_W-1:0] thr;

   assign rise_up  = up_v & ~up_q;
   assign rise_dn  = dn_v & ~dn_q;
   assign gap_next = cnt + GAP_W'(1);
   assign thr      = GAP_W'((int'(thr_code_i) + 1) * THR_UNIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         up_q   <= 1'b0;
         dn_q   <= 1'b0;
         state  <= GM_IDLE;
         cnt    <= '0;
         done_o <= 1'b0;
         good_o <= 1'b0;
      end else begin
         up_q   <= up_v;
         dn_q   <= dn_v;
         done_o <= 1'b0;
         good_o <= 1'b0;
         unique case (state)
            GM_IDLE: begin
               cnt <= '0;
               if (rise_up && rise_dn) begin
                  done_o <= 1'b1;
                  good_o <= (thr != '0);
               end else if (rise_up) begin
                  state <= GM_WAIT_DN;
               end else if (rise_dn) begin
                  state <= GM_WAIT_UP;
               end
            end
            GM_WAIT_DN, GM_WAIT_UP: begin
               if ((state == GM_WAIT_DN) ? rise_dn : rise_up) begin
                  done_o <= 1'b1;
                  good_o <= (gap_next < thr);
                  state  <= GM_IDLE;
               end else if ((state == GM_WAIT_DN) ? rise_up : rise_dn) begin
                  done_o <= 1'b1;
                  state  <= GM_IDLE;
               end else if (gap_next >= GAP_W'(TIMEOUT_TICKS)) begin
                  done_o <= 1'b1;
                  state  <= GM_IDLE;
               end else begin
                  cnt <= gap_next;
               end
            end
            default: state <= GM_IDLE;
         endcase
      end
   end

   AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < GAP_W'(TIMEOUT_TICKS)) else $error("wait counter overran"); // R6
   AST_GOOD_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      good_o |-> done_o) else $error("good without result"); // R2

endmodule

// File: rtl/lockdet_run_counter.sv
module lockdet_run_counter
   import lockdet_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done_i,
   input  logic       good_i,
   input  logic [2:0] cnt_code_i,
   output logic       locked_o
);

   logic [RUN_W-1:0] run;
   logic [RUN_W-1:0] need;
   logic [RUN_W:0]   run_inc;

   assign need    = need_cycles(cnt_code_i);
   assign run_inc = {1'b0, run} + (RUN_W + 1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run      <= '0;
         locked_o <= 1'b0;
      end else if (done_i) begin
         if (good_i) begin
            if (run < need) run <= run + RUN_W'(1);
            locked_o <= (run_inc >= {1'b0, need});
         end else begin
            run      <= '0;
            locked_o <= 1'b0;
         end
      end
   end

   AST_LOCK_FROM_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(done_i && good_i)) else $error("lock without good cycle"); // R4
   AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !good_i) |=> !locked_o) else $error("bad cycle kept lock"); // R5
   AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run <= RUN_W'(4096)) else $error("run counter overflow"); // R4

endmodule

// File: rtl/lockdet_restart_gen.sv
module lockdet_restart_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic locked_i,
   input  logic auto_en_i,
   input  logic busy_i,
   output logic strobe_o
);

   logic locked_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_d <= 1'b0;
         strobe_o <= 1'b0;
      end else begin
         locked_d <= locked_i;
         strobe_o <= locked_d & ~locked_i & auto_en_i & ~busy_i;
      end
   end

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o) else $error("strobe longer than one clock"); // R8
   AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> $past(auto_en_i && !busy_i)) else $error("strobe while gated"); // R9

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
   parameter int unsigned TICK_PS       = 500,
   parameter int unsigned TIMEOUT_TICKS = 48,
   parameter int unsigned IN_SYNC       = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pfd_up_i,
   input  logic       pfd_dn_i,
   input  logic [2:0] thr_code_i,
   input  logic [2:0] cnt_code_i,
   input  logic       lock_act_low_i,
   input  logic       autocal_en_i,
   input  logic       cal_busy_i,
   output logic       lock_o,
   output logic       cal_restart_o
);

   logic cyc_done, cyc_good, locked;

   lockdet_gap_meter #(
      .TICK_PS      (TICK_PS),
      .TIMEOUT_TICKS(TIMEOUT_TICKS),
      .IN_SYNC      (IN_SYNC)
   ) u_gap (
      .clk       (clk),
      .rst_n     (rst_n),
      .up_i      (pfd_up_i),
      .dn_i      (pfd_dn_i),
      .thr_code_i(thr_code_i),
      .done_o    (cyc_done),
      .good_o    (cyc_good)
   );

   lockdet_run_counter u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (cyc_done),
      .good_i    (cyc_good),
      .cnt_code_i(cnt_code_i),
      .locked_o  (locked)
   );

   lockdet_restart_gen u_rst (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked_i (locked),
      .auto_en_i(autocal_en_i),
      .busy_i   (cal_busy_i),
      .strobe_o (cal_restart_o)
   );

   assign lock_o = locked ^ lock_act_low_i;

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !cal_restart_o) else $error("strobe after reset"); // R1

endmodule

// File: tb/sim_pll_lock_detect.sv
module sim_pll_lock_detect;

   localparam int TIMEOUT = 48;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       up = 1'b0, dn = 1'b0;
   logic [2:0] thr_code = 3'd7, cnt_code = 3'd0;
   logic       act_low = 1'b0, auto_en = 1'b0, busy = 1'b0;
   logic       lock_o, restart_o;

   int checks = 0;
   int errors = 0;
   int strobes = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pll_lock_detect #(.TICK_PS(500), .TIMEOUT_TICKS(TIMEOUT), .IN_SYNC(1)) u0 (
      .clk(clk), .rst_n(rst_n), .pfd_up_i(up), .pfd_dn_i(dn),
      .thr_code_i(thr_code), .cnt_code_i(cnt_code), .lock_act_low_i(act_low),
      .autocal_en_i(auto_en), .cal_busy_i(busy),
      .lock_o(lock_o), .cal_restart_o(restart_o)
   );

   always @(negedge clk) if (rst_n && restart_o) strobes++;

   task automatic chk(input int got, input int exp, input string req);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", req, got, exp);
      end
   endtask

   function automatic int need_of(input int code);
      return (code < 5) ? (4 << code) : (64 << (2 * (code - 4)));
   endfunction

   // one PFD cycle: first edge, gap edges later the other edge
   task automatic pfd_cycle(input bit up_first, input int gap);
      @(negedge clk);
      if (gap == 0) begin up = 1; dn = 1; end
      else if (up_first) up = 1;
      else dn = 1;
      repeat (gap) @(negedge clk);
      up = 1; dn = 1;
      repeat (3) @(negedge clk);
      up = 0; dn = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic missing_edge();
      @(negedge clk);
      up = 1;
      repeat (TIMEOUT + 8) @(negedge clk);
      up = 0;
      repeat (4) @(negedge clk);
   endtask

   task automatic double_up();
      @(negedge clk);
      up = 1; repeat (3) @(negedge clk);
      up = 0; repeat (3) @(negedge clk);
      up = 1; repeat (3) @(negedge clk);
      up = 0; repeat (8) @(negedge clk);
   endtask

   task automatic good_run(input int n);
      for (int i = 0; i < n; i++) pfd_cycle(i[0], 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(lock_o, 0, "R1 lock after reset");
      chk(restart_o, 0, "R1 strobe after reset");
      rst_n = 1;
      @(negedge clk);
      chk(lock_o, 0, "R1 lock out of reset");
      act_low = 1; @(negedge clk);
      chk(lock_o, 1, "R7 active-low unlocked");
      act_low = 0;

      // R2 R3 threshold sweep, run of 4
      cnt_code = 3'd0;
      for (int tc = 0; tc < 8; tc++) begin
         int thr_t;
         thr_t = 4 * (tc + 1);
         thr_code = 3'(tc);
         missing_edge();
         for (int i = 0; i < 3; i++) pfd_cycle(i[0], thr_t - 1);
         chk(lock_o, 0, "R4 three of four good");
         pfd_cycle(1'b0, thr_t - 1);
         chk(lock_o, 1, "R3 gap one under threshold is good");
         pfd_cycle(1'b0, thr_t);
         chk(lock_o, 0, "R2 gap equal to threshold is bad");
      end

      // R4 run-length sweep
      thr_code = 3'd7;
      for (int cc = 0; cc < 8; cc++) begin
         cnt_code = 3'(cc);
         missing_edge();
         good_run(need_of(cc) - 1);
         chk(lock_o, 0, "R4 one cycle short");
         pfd_cycle(1'b1, 0);
         chk(lock_o, 1, "R4 exact run length");
      end

      // R5 bad cycle clears run
      cnt_code = 3'd0; thr_code = 3'd0;
      pfd_cycle(1'b1, 6);
      chk(lock_o, 0, "R5 bad cycle drops lock");
      good_run(3);
      chk(lock_o, 0, "R5 run restarted");
      good_run(1);
      chk(lock_o, 1, "R5 relock after full run");
      good_run(2);
      chk(lock_o, 1, "R4 lock held on further good");

      // R6 missing edge and repeated edge
      missing_edge();
      chk(lock_o, 0, "R6 missing edge is bad");
      good_run(4);
      chk(lock_o, 1, "R6 relock");
      double_up();
      chk(lock_o, 0, "R6 repeated edge is bad");

      // R7 polarity while locked
      good_run(4);
      act_low = 1; @(negedge clk);
      chk(lock_o, 0, "R7 active-low locked");
      act_low = 0; @(negedge clk);
      chk(lock_o, 1, "R7 active-high locked");

      // R8 strobe on loss, none on gain
      auto_en = 1; busy = 0;
      missing_edge();
      strobes = 0;
      good_run(4);
      chk(strobes, 0, "R8 no strobe when gaining lock");
      missing_edge();
      chk(strobes, 1, "R8 one strobe on loss");

      // R9 gated cases
      good_run(4);
      busy = 1; strobes = 0;
      missing_edge();
      chk(strobes, 0, "R9 busy suppresses strobe");
      busy = 0;
      good_run(4);
      auto_en = 0; strobes = 0;
      missing_edge();
      chk(strobes, 0, "R9 disabled suppresses strobe");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule